// File: doc/BRIEF.md
# Two-Level SMI Event Aggregator with I/O Address Trap

The block gathers interrupt-class events into two stacked banks of sticky flags. The lower bank captures native hardware events. Each lower flag is masked by its own enable, and the enabled flags are ORed into one summary. That summary acts as the event for bit 0 of the upper bank. The upper bank also takes external SMI sources and the I/O trap hits. Its enabled flags are ORed into the `smi` output to the processor. A handler clears the flags it services. `smi` stays high while any enabled flag is still set, so events that arrive during servicing make the handler run again.

The trap unit watches host I/O accesses. Each trap has its own base address, don't-care mask, enable and read-trap option. A matching access is not forwarded to the target. Its address, direction, write data and trap index are captured. Its upper flag is raised, and the host's ready is held back until `smi` has already risen, so the trap appears at the instruction boundary. A trapped access then completes with no side effect, and reads return all ones.

Register offsets on the software port (`sw_addr`): 0 lower flags (read; write-one-to-clear), 1 lower set (write-one-to-set), 2 lower enables, 3 upper flags (read; write-one-to-clear), 4 upper set, 5 upper enables, 6 trap control (bit t = trap t enable, bit 8+t = trap t also traps reads), 7 captured address, 8 captured info (bit 0 = was a write, bits 8 and up = trap index), 9 captured write data, 16+2t trap t base, 17+2t trap t mask (a 1 means the address bit is ignored). Upper flag layout: bit 0 = lower summary, bits 1..N_EXT = `ext_smi`, then one bit per trap in index order.

Top module: `smi_cascade_top`

## Requirements
- R1: A native event pulse sets its lower flag at the next clock edge. The flag stays set after the event goes away, until software clears it.
- R2: Writing ones to a set register forces those flags high. Writing ones to a flag register clears only the bits written as one.
- R3: While any enabled lower flag is set, upper flag bit 0 is set at the next edge. A disabled lower flag never reaches the upper bank.
- R4: `smi` is high exactly when some upper flag and its enable are both set. It stays high until every enabled flag is cleared or disabled.
- R5: When an event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: An access hits trap t when the trap is enabled and the address matches the base on all bits where the mask is 0. Writes always qualify, and reads qualify only if the read-trap bit is set. A hit access is not forwarded (`tgt_req` stays low).
- R7: A trap hit sets that trap's upper flag at the next edge, so `smi` rises there if the flag is enabled. `io_rdy` pulses one cycle later, with `io_rdata` all ones.
- R8: On a trap hit, the captured address, direction, write data and the lowest hitting trap index become readable.
- R9: After reset, all flags, enables and trap controls read zero and `smi` is low.
- R10: A non-trapped access is forwarded in the same cycle. `io_rdy` and `io_rdata` follow `tgt_rdy` and `tgt_rdata` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| native_evt | input | N_EVT | Lower-bank event pulses |
| ext_smi | input | N_EXT | Other upper-bank event sources |
| sw_sel | input | 1 | Software port select |
| sw_wr | input | 1 | Software write strobe (with sw_sel) |
| sw_addr | input | 6 | Register offset |
| sw_wdata | input | DW | Register write data |
| sw_rdata | output | DW | Register read data (combinational) |
| io_req | input | 1 | Host I/O access strobe, one cycle |
| io_wr | input | 1 | Host access is a write |
| io_addr | input | AW | Host I/O address |
| io_wdata | input | DW | Host write data |
| io_rdy | output | 1 | Host access complete |
| io_rdata | output | DW | Host read data |
| tgt_req | output | 1 | Forwarded access strobe |
| tgt_wr | output | 1 | Forwarded direction |
| tgt_addr | output | AW | Forwarded address |
| tgt_wdata | output | DW | Forwarded write data |
| tgt_rdy | input | 1 | Target completion |
| tgt_rdata | input | DW | Target read data |
| smi | output | 1 | SMI request to the processor |

## Verification
A native event shows up in the lower flags one edge after the pulse. It shows up in upper bit 0 and on `smi` one edge later again. A trap hit raises `smi` one edge after the request and `io_rdy` one edge after that. Forwarding and software reads are combinational. The bench drives every input on a falling edge and samples one falling edge per register stage on the path, so each result is read at the half cycle in which it first becomes valid. It then sweeps all enable patterns against every event bit, and a window of addresses around both trap ranges in both directions.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] RA_LO_FLAG  = 6'd0;
  localparam logic [REG_AW-1:0] RA_LO_SET   = 6'd1;
  localparam logic [REG_AW-1:0] RA_LO_EN    = 6'd2;
  localparam logic [REG_AW-1:0] RA_UP_FLAG  = 6'd3;
  localparam logic [REG_AW-1:0] RA_UP_SET   = 6'd4;
  localparam logic [REG_AW-1:0] RA_UP_EN    = 6'd5;
  localparam logic [REG_AW-1:0] RA_TRAP_CTL = 6'd6;
  localparam logic [REG_AW-1:0] RA_CAP_ADDR = 6'd7;
  localparam logic [REG_AW-1:0] RA_CAP_INFO = 6'd8;
  localparam logic [REG_AW-1:0] RA_CAP_DATA = 6'd9;
  localparam int RA_TRAP_BASE = 16;
  localparam int CTL_RD_LSB   = 8;
endpackage

// File: rtl/smi_flag_bank.sv
module smi_flag_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags,
  output logic [W-1:0] en,
  output logic         summary
);
  logic [W-1:0] flags_d, en_d;
  logic         flags_ce;

  always_comb begin
    flags_d = flags;
    if (clr_we) flags_d = flags_d & ~wdata;
    if (set_we) flags_d = flags_d | wdata;
    flags_d  = flags_d | evt;            // hardware event beats a clear
    flags_ce = clr_we | set_we | (|evt);
    en_d     = en_we ? wdata : en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
    end else begin
      if (flags_ce) flags <= flags_d;
      if (en_we)    en    <= en_d;
    end
  end

  assign summary = |(flags & en);
endmodule

// File: rtl/smi_io_trap.sv
module smi_io_trap #(
  parameter int NT = 2,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  wr,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  input  logic [NT-1:0]         trap_en,
  input  logic [NT-1:0]         trap_rd,
  input  logic [NT-1:0][AW-1:0] base,
  input  logic [NT-1:0][AW-1:0] mask,
  output logic [NT-1:0]         hit_vec,
  output logic                  hit_any,
  output logic                  trap_rdy,
  output logic [AW-1:0]         cap_addr,
  output logic                  cap_wr,
  output logic [IW-1:0]         cap_idx,
  output logic [DW-1:0]         cap_data
);
  logic          pend_q, pend_d, rdy_d;
  logic [IW-1:0] idx_d;

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      hit_vec[t] = req & trap_en[t] & (wr | trap_rd[t]) &
                   (((addr ^ base[t]) & ~mask[t]) == '0);
    end
    hit_any = |hit_vec;
    idx_d   = '0;
    for (int t = NT - 1; t >= 0; t--) begin
      if (hit_vec[t]) idx_d = IW'(t);
    end
    pend_d = hit_any;
    rdy_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      trap_rdy <= 1'b0;
      cap_addr <= '0;
      cap_wr   <= 1'b0;
      cap_idx  <= '0;
      cap_data <= '0;
    end else begin
      pend_q   <= pend_d;
      trap_rdy <= rdy_d;
      if (hit_any) begin
        cap_addr <= addr;
        cap_wr   <= wr;
        cap_idx  <= idx_d;
        cap_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/smi_cascade_top.sv
module smi_cascade_top
  import smi_pkg::*;
#(
  parameter int N_EVT  = 4,
  parameter int N_EXT  = 2,
  parameter int N_TRAP = 2,
  parameter int AW     = 16,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  native_evt,
  input  logic [N_EXT-1:0]  ext_smi,
  input  logic              sw_sel,
  input  logic              sw_wr,
  input  logic [REG_AW-1:0] sw_addr,
  input  logic [DW-1:0]     sw_wdata,
  output logic [DW-1:0]     sw_rdata,
  input  logic              io_req,
  input  logic              io_wr,
  input  logic [AW-1:0]     io_addr,
  input  logic [DW-1:0]     io_wdata,
  output logic              io_rdy,
  output logic [DW-1:0]     io_rdata,
  output logic              tgt_req,
  output logic              tgt_wr,
  output logic [AW-1:0]     tgt_addr,
  output logic [DW-1:0]     tgt_wdata,
  input  logic              tgt_rdy,
  input  logic [DW-1:0]     tgt_rdata,
  output logic              smi
);
  localparam int UW = 1 + N_EXT + N_TRAP;
  localparam int IW = (N_TRAP > 1) ? $clog2(N_TRAP) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic sw_we;
  assign sw_we = sw_sel & sw_wr;

  // trap configuration
  logic [N_TRAP-1:0]         trap_en_q, trap_en_d, trap_rd_q, trap_rd_d;
  logic [N_TRAP-1:0][AW-1:0] base_q, base_d, mask_q, mask_d;
  logic                      ctl_we;
  logic [N_TRAP-1:0]         base_we, mask_we;

  always_comb begin
    ctl_we    = sw_we & (sw_addr == RA_TRAP_CTL);
    trap_en_d = ctl_we ? sw_wdata[N_TRAP-1:0] : trap_en_q;
    trap_rd_d = ctl_we ? sw_wdata[CTL_RD_LSB +: N_TRAP] : trap_rd_q;
    for (int t = 0; t < N_TRAP; t++) begin
      base_we[t] = sw_we & (sw_addr == REG_AW'(RA_TRAP_BASE + 2 * t));
      mask_we[t] = sw_we & (sw_addr == REG_AW'(RA_TRAP_BASE + 2 * t + 1));
      base_d[t]  = base_we[t] ? sw_wdata[AW-1:0] : base_q[t];
      mask_d[t]  = mask_we[t] ? sw_wdata[AW-1:0] : mask_q[t];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_en_q <= '0;
      trap_rd_q <= '0;
      base_q    <= '0;
      mask_q    <= '0;
    end else begin
      if (ctl_we) begin
        trap_en_q <= trap_en_d;
        trap_rd_q <= trap_rd_d;
      end
      for (int t = 0; t < N_TRAP; t++) begin
        if (base_we[t]) base_q[t] <= base_d[t];
        if (mask_we[t]) mask_q[t] <= mask_d[t];
      end
    end
  end

  // trap unit
  logic [N_TRAP-1:0] trap_hit_vec;
  logic              hit_any, trap_rdy, cap_wr;
  logic [AW-1:0]     cap_addr;
  logic [IW-1:0]     cap_idx;
  logic [DW-1:0]     cap_data;

  smi_io_trap #(.NT(N_TRAP), .AW(AW), .DW(DW), .IW(IW)) u_trap (
    .clk(clk), .rst_n(rst_ni), .req(io_req), .wr(io_wr), .addr(io_addr),
    .wdata(io_wdata), .trap_en(trap_en_q), .trap_rd(trap_rd_q),
    .base(base_q), .mask(mask_q), .hit_vec(trap_hit_vec), .hit_any(hit_any),
    .trap_rdy(trap_rdy), .cap_addr(cap_addr), .cap_wr(cap_wr),
    .cap_idx(cap_idx), .cap_data(cap_data)
  );

  assign tgt_req   = io_req & ~hit_any;
  assign tgt_wr    = io_wr;
  assign tgt_addr  = io_addr;
  assign tgt_wdata = io_wdata;
  assign io_rdy    = tgt_rdy | trap_rdy;
  assign io_rdata  = trap_rdy ? {DW{1'b1}} : tgt_rdata;

  // two cascaded flag banks
  logic [N_EVT-1:0] lo_flags, lo_en;
  logic [UW-1:0]    up_flags, up_en, up_evt;
  logic             lo_summary;

  smi_flag_bank #(.W(N_EVT)) u_lo (
    .clk(clk), .rst_n(rst_ni), .evt(native_evt),
    .set_we(sw_we & (sw_addr == RA_LO_SET)),
    .clr_we(sw_we & (sw_addr == RA_LO_FLAG)),
    .en_we(sw_we & (sw_addr == RA_LO_EN)),
    .wdata(sw_wdata[N_EVT-1:0]), .flags(lo_flags), .en(lo_en),
    .summary(lo_summary)
  );

  assign up_evt = {trap_hit_vec, ext_smi, lo_summary};

  smi_flag_bank #(.W(UW)) u_up (
    .clk(clk), .rst_n(rst_ni), .evt(up_evt),
    .set_we(sw_we & (sw_addr == RA_UP_SET)),
    .clr_we(sw_we & (sw_addr == RA_UP_FLAG)),
    .en_we(sw_we & (sw_addr == RA_UP_EN)),
    .wdata(sw_wdata[UW-1:0]), .flags(up_flags), .en(up_en),
    .summary(smi)
  );

  // software read mux
  always_comb begin
    sw_rdata = '0;
    case (sw_addr)
      RA_LO_FLAG:  sw_rdata = DW'(lo_flags);
      RA_LO_EN:    sw_rdata = DW'(lo_en);
      RA_UP_FLAG:  sw_rdata = DW'(up_flags);
      RA_UP_EN:    sw_rdata = DW'(up_en);
      RA_TRAP_CTL: sw_rdata = DW'(trap_en_q) | (DW'(trap_rd_q) << CTL_RD_LSB);
      RA_CAP_ADDR: sw_rdata = DW'(cap_addr);
      RA_CAP_INFO: sw_rdata = DW'(cap_wr) | (DW'(cap_idx) << 8);
      RA_CAP_DATA: sw_rdata = cap_data;
      default: begin
        for (int t = 0; t < N_TRAP; t++) begin
          if (sw_addr == REG_AW'(RA_TRAP_BASE + 2 * t))     sw_rdata = DW'(base_q[t]);
          if (sw_addr == REG_AW'(RA_TRAP_BASE + 2 * t + 1)) sw_rdata = DW'(mask_q[t]);
        end
      end
    endcase
  end
endmodule

// File: rtl/smi_cascade_chk.sv
module smi_cascade_chk #(
  parameter int N_EXT  = 2,
  parameter int N_TRAP = 2,
  parameter int UW     = 5
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              smi,
  input logic              io_req,
  input logic              hit_any,
  input logic [N_TRAP-1:0] hit_vec,
  input logic              trap_rdy,
  input logic              lo_summary,
  input logic [UW-1:0]     up_flags,
  input logic [UW-1:0]     up_en,
  input logic [N_EXT-1:0]  ext_smi,
  input logic              sw_sel,
  input logic              sw_wr
);
  // lower summary reaches upper bit 0 one edge later
  assert_summary_lifts_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    lo_summary |=> up_flags[0]);

  // without any software write, smi cannot drop
  assert_smi_holds_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (smi && !(sw_sel && sw_wr)) |=> smi);

  // an event always leaves its flag set, clear or not
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    ext_smi[0] |=> up_flags[1]);

  // an enabled trap hit raises smi at the next edge
  assert_smi_before_rdy_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (io_req && |(hit_vec & up_en[UW-1 -: N_TRAP]) && !(sw_sel && sw_wr)) |=> smi);

  // trapped completion comes exactly two edges after the hit
  assert_trap_rdy_late_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    trap_rdy |-> $past(io_req && hit_any, 2));
endmodule

bind smi_cascade_top smi_cascade_chk #(.N_EXT(N_EXT), .N_TRAP(N_TRAP), .UW(UW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .smi(smi), .io_req(io_req), .hit_any(hit_any),
  .hit_vec(trap_hit_vec), .trap_rdy(trap_rdy), .lo_summary(lo_summary),
  .up_flags(up_flags), .up_en(up_en), .ext_smi(ext_smi),
  .sw_sel(sw_sel), .sw_wr(sw_wr)
);

// File: tb/smi_cascade_top_test.sv
module smi_cascade_top_test;
  localparam int N_EVT = 4, N_EXT = 2, N_TRAP = 2, AW = 16, DW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_EVT-1:0]  native_evt = '0;
  logic [N_EXT-1:0]  ext_smi = '0;
  logic              sw_sel = 1'b0, sw_wr = 1'b0;
  logic [5:0]        sw_addr = '0;
  logic [DW-1:0]     sw_wdata = '0, sw_rdata;
  logic              io_req = 1'b0, io_wr = 1'b0, io_rdy;
  logic [AW-1:0]     io_addr = '0, tgt_addr;
  logic [DW-1:0]     io_wdata = '0, io_rdata, tgt_wdata;
  logic              tgt_req, tgt_wr, tgt_rdy = 1'b0, smi;
  logic [DW-1:0]     tgt_rdata = '0;

  int vectors = 0, errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  smi_cascade_top #(.N_EVT(N_EVT), .N_EXT(N_EXT), .N_TRAP(N_TRAP), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .native_evt(native_evt), .ext_smi(ext_smi),
    .sw_sel(sw_sel), .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdy(io_rdy), .io_rdata(io_rdata),
    .tgt_req(tgt_req), .tgt_wr(tgt_wr), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_rdy(tgt_rdy), .tgt_rdata(tgt_rdata), .smi(smi)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    sw_sel = 1'b1; sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_sel = 1'b0; sw_wr = 1'b0;
  endtask

  task automatic sw_read(input logic [5:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    sw_sel = 1'b1; sw_wr = 1'b0; sw_addr = a;
    #1 d = sw_rdata;
    sw_sel = 1'b0;
  endtask

  task automatic clear_all();
    sw_write(6'd0, '1);
    sw_write(6'd3, '1);
  endtask

  // one host access; exp_hit and expected trap index come from the bench's own model
  task automatic access(input logic [AW-1:0] a, input logic w, input logic exp_hit,
                        input int exp_idx);
    logic [DW-1:0] d, r;
    d = 32'hC0DE_0000 | DW'(a);
    clear_all();
    @(negedge clk);
    io_req = 1'b1; io_wr = w; io_addr = a; io_wdata = d;
    #1;
    check(exp_hit ? "R6 trapped not forwarded" : "R10 forwarded", DW'(tgt_req), DW'(!exp_hit));
    @(negedge clk);
    io_req = 1'b0;
    if (exp_hit) begin
      check("R7 smi up, no ready yet", DW'({smi, io_rdy}), DW'(2'b10));
      @(negedge clk);
      check("R7 trapped ready", DW'(io_rdy), 32'd1);
      check("R7 trapped data all ones", io_rdata, '1);
      sw_read(6'd7, r); check("R8 captured address", r, DW'(a));
      sw_read(6'd8, r); check("R8 captured info", r, DW'(w) | (DW'(exp_idx) << 8));
      if (w) begin
        sw_read(6'd9, r); check("R8 captured data", r, d);
      end
    end else begin
      tgt_rdy = 1'b1; tgt_rdata = 32'h5A00_0000 | DW'(a);
      #1;
      check("R10 ready passthrough", DW'({io_rdy, smi}), DW'(2'b10));
      check("R10 data passthrough", io_rdata, 32'h5A00_0000 | DW'(a));
      @(negedge clk);
      tgt_rdy = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset values
    check("R9 smi low", DW'(smi), 32'd0);
    sw_read(6'd0, r); check("R9 lower flags", r, 0);
    sw_read(6'd2, r); check("R9 lower enables", r, 0);
    sw_read(6'd3, r); check("R9 upper flags", r, 0);
    sw_read(6'd5, r); check("R9 upper enables", r, 0);
    sw_read(6'd6, r); check("R9 trap control", r, 0);

    // R1/R3/R4 sweep: every lower enable pattern against every event bit
    sw_write(6'd5, 32'h1);
    for (int en = 0; en < 16; en++) begin
      sw_write(6'd2, DW'(en));
      for (int ev = 0; ev < N_EVT; ev++) begin
        clear_all();
        @(negedge clk);
        native_evt = N_EVT'(1 << ev);
        @(negedge clk);
        native_evt = '0;
        @(negedge clk);
        check("R4 smi from lower event", DW'(smi), DW'((en >> ev) & 1));
        sw_read(6'd0, r); check("R1 lower flag sticky", r, DW'(1 << ev));
        sw_read(6'd3, r); check("R3 upper bit0", r, DW'((en >> ev) & 1));
      end
    end

    // R2 set and selective clear
    sw_write(6'd2, 0);
    clear_all();
    sw_write(6'd1, 32'hA);
    sw_read(6'd0, r); check("R2 set forces flags", r, 32'hA);
    sw_write(6'd0, 32'h2);
    sw_read(6'd0, r); check("R2 clear only written bits", r, 32'h8);
    sw_write(6'd0, '1);

    // R4 masking and hold until all enabled flags cleared
    sw_write(6'd5, 32'h0);
    sw_write(6'd3, '1);
    sw_write(6'd4, 32'h6);
    @(negedge clk);
    check("R4 disabled flags keep smi low", DW'(smi), 0);
    sw_write(6'd5, 32'h6);
    @(negedge clk);
    check("R4 enabled flags raise smi", DW'(smi), 1);
    sw_write(6'd3, 32'h2);
    @(negedge clk);
    check("R4 one flag left keeps smi", DW'(smi), 1);
    sw_write(6'd3, 32'h4);
    @(negedge clk);
    check("R4 all cleared drops smi", DW'(smi), 0);

    // R5 event and clear collide on upper bit 1
    @(negedge clk);
    ext_smi = 2'b01;
    sw_sel = 1'b1; sw_wr = 1'b1; sw_addr = 6'd3; sw_wdata = 32'h2;
    @(negedge clk);
    ext_smi = '0; sw_sel = 1'b0; sw_wr = 1'b0;
    sw_read(6'd3, r); check("R5 event beats clear", r & 32'h2, 32'h2);
    sw_write(6'd3, 32'h2);
    sw_read(6'd3, r); check("R5 clear alone works", r & 32'h2, 32'h0);

    // trap configuration: trap0 0x0120/0x000F writes only, trap1 0x0300/0x0003 reads too
    sw_write(6'd2, 0);
    sw_write(6'd5, 32'h1F);
    sw_write(6'd16, 32'h0120); sw_write(6'd17, 32'h000F);
    sw_write(6'd18, 32'h0300); sw_write(6'd19, 32'h0003);
    sw_write(6'd6, 32'h0203);
    sw_read(6'd6, r); check("R6 trap control readback", r, 32'h0203);
    for (int w = 0; w < 2; w++) begin
      for (int a = 16'h0118; a <= 16'h0132; a++) begin
        access(AW'(a), w[0], w[0] && ((a & 16'hFFF0) == 16'h0120), 0);
      end
      for (int a = 16'h02FC; a <= 16'h0306; a++) begin
        access(AW'(a), w[0], (a & 16'hFFFC) == 16'h0300, 1);
      end
    end

    // R6 disabled traps never hit
    sw_write(6'd6, 32'h0);
    access(16'h0125, 1'b1, 1'b0, 0);
    access(16'h0301, 1'b0, 1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule